// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Write Target

This block is the target side of a 4-bit multiplexed firmware bus and handles single-byte write frames. It watches an active-low frame strobe and the bus nibble on every rising edge of the bus clock. A frame starts with a start code. A device-select nibble follows, which is compared against a strapped ID. Next come a 28-bit address, sent as seven nibbles, and a size nibble. The data byte arrives last, low nibble first.

Once the host has released the bus over two turnaround clocks, the target takes ownership. It drives a sync acknowledge nibble for one clock and then all ones for one clock, and then floats the bus again. The complete frame lasts 17 clocks. The tri-state pad sits outside the block, so the bus appears here as an input nibble, an output nibble and an output enable.

The received address and byte are handed downstream as a one-clock write strobe during the sync clock. A frame with a bad start code, a foreign ID or an unsupported size is dropped silently. A frame-strobe assertion in the middle of a frame abandons that frame.

Top module: `nbus_wr_target`

## Requirements
- R1: A frame is recognised only when `frame_n` is low while `bus_in` carries the start code 4'b1110. A frame whose start nibble has any other value produces no strobe and never enables the bus.
- R2: While `frame_n` stays low over several clocks, only the nibble sampled on the last low clock is taken as the start code.
- R3: The nibble on the first clock after `frame_n` rises is the device select. The frame continues only if this nibble equals `strap_id`. Otherwise the block stays silent.
- R4: The next seven nibbles form `wr_addr`, most significant nibble first (clock 3 carries bits 27:24 and clock 9 carries bits 3:0).
- R5: The nibble on clock 10 is the size. Only 4'b0000 (one byte) is accepted. Any other value drops the frame without strobe or bus drive.
- R6: Clock 11 carries `wr_data[3:0]` and clock 12 carries `wr_data[7:4]`.
- R7: During clock 15 of an accepted frame, `bus_oe` is 1 and `bus_out` is 4'b0000 (sync acknowledge).
- R8: During clock 16, `bus_oe` is 1 and `bus_out` is 4'b1111. From clock 17 `bus_oe` is 0. `bus_oe` is never 1 on any other clock.
- R9: `wr_stb` is high for exactly one clock, the sync clock, and `wr_addr` and `wr_data` are valid while it is high.
- R10: `frame_n` sampled low at any point of a frame abandons that frame: no strobe and no bus drive follow for it, and start detection begins again.
- R11: A low `rst_n` at a rising edge returns the block to idle, with `bus_oe` and `wr_stb` low after that edge, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame strobe, active low |
| strap_id | input | 4 | Device ID this target answers to |
| bus_in | input | 4 | Nibble sampled from the bus |
| bus_out | output | 4 | Nibble driven when `bus_oe` is high |
| bus_oe | output | 1 | Output enable for the bus pad |
| wr_stb | output | 1 | One-clock write strobe |
| wr_addr | output | 28 | Received write address |
| wr_data | output | 8 | Received write byte |

## Verification
Directed frames cover the following cases:
- A clean write, which shows that address nibble order, data nibble order and sync timing land on the right clocks.
- Frames that each fail one gate (start code, device ID or size). These show that each check blocks the frame by itself.
- Pairs of multi-clock start fields with the valid code first and then last. These tell "last start nibble wins" apart from "any start nibble wins".
- Aborts at the address and turnaround phases, and resets at the address and sync clocks, each followed by a clean frame. These show that no stale strobe escapes and that the next frame decodes normally.

Random frames from a fixed seed mix stray start nibbles, foreign IDs, non-zero sizes, changing straps and random aborts with idle gaps. They are compared clock by clock against a bench model of acceptance.

// File: rtl/nbus_wr_pkg.sv
package nbus_wr_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_STRT,
      ST_ADDR,
      ST_SIZE,
      ST_DATA,
      ST_HTA0,
      ST_HTA1,
      ST_SYNC,
      ST_TTAR
   } nbus_state_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/nbus_start_track.sv
module nbus_start_track #(
   parameter int                NIB_W      = 4,
   parameter logic [NIB_W-1:0]  START_CODE = 4'b1110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic [NIB_W-1:0] nib,
   output logic             armed
);

   initial begin
      assert (NIB_W >= 2);
   end

   // every low frame clock overwrites the verdict, so the last one wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (!frame_n) begin
         armed <= (nib == START_CODE);
      end
   end

endmodule

// File: rtl/nbus_nib_collect.sv
module nbus_nib_collect #(
   parameter int NIB_W     = 4,
   parameter int NIBS      = 7,
   parameter bit MSB_FIRST = 1'b1,
   localparam int VAL_W    = NIB_W * NIBS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic [NIB_W-1:0] nib,
   output logic [VAL_W-1:0] value
);

   initial begin
      assert (NIBS >= 1);
      assert (NIB_W >= 1);
   end

   logic [VAL_W-1:0] nxt_val;

   generate
      if (NIBS == 1) begin : g_single
         assign nxt_val = nib;
      end else if (MSB_FIRST) begin : g_msb_first
         assign nxt_val = {value[VAL_W-NIB_W-1:0], nib};
      end else begin : g_lsb_first
         assign nxt_val = {nib, value[VAL_W-1:NIB_W]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
      end else if (shift) begin
         value <= nxt_val;
      end
   end

endmodule

// File: rtl/nbus_wr_seq.sv
module nbus_wr_seq
   import nbus_wr_pkg::*;
#(
   parameter int                NIB_W     = 4,
   parameter int                ADDR_NIBS = 7,
   parameter int                DATA_NIBS = 2,
   parameter logic [NIB_W-1:0]  SIZE_ONE  = 4'b0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic [NIB_W-1:0] nib,
   input  logic [NIB_W-1:0] strap_id,
   input  logic             armed,
   output nbus_state_e      state,
   output logic             addr_shift,
   output logic             data_shift
);

   localparam int MAXN  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
   localparam int CNT_W = cnt_bits(MAXN);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

   initial begin
      assert (ADDR_NIBS >= 1);
      assert (DATA_NIBS >= 1);
   end

   nbus_state_e      nxt_state;
   logic [CNT_W-1:0] cnt, nxt_cnt;

   always_comb begin
      nxt_state  = state;
      nxt_cnt    = cnt;
      addr_shift = 1'b0;
      data_shift = 1'b0;
      if (!frame_n) begin
         nxt_state = ST_STRT;
         nxt_cnt   = '0;
      end else begin
         unique case (state)
            ST_IDLE: nxt_state = ST_IDLE;
            ST_STRT: begin
               nxt_cnt   = '0;
               nxt_state = (armed && nib == strap_id) ? ST_ADDR : ST_IDLE;
            end
            ST_ADDR: begin
               addr_shift = 1'b1;
               if (cnt == ADDR_LAST) begin
                  nxt_cnt   = '0;
                  nxt_state = ST_SIZE;
               end else begin
                  nxt_cnt = cnt + 1'b1;
               end
            end
            ST_SIZE: nxt_state = (nib == SIZE_ONE) ? ST_DATA : ST_IDLE;
            ST_DATA: begin
               data_shift = 1'b1;
               if (cnt == DATA_LAST) begin
                  nxt_cnt   = '0;
                  nxt_state = ST_HTA0;
               end else begin
                  nxt_cnt = cnt + 1'b1;
               end
            end
            ST_HTA0: nxt_state = ST_HTA1;
            ST_HTA1: nxt_state = ST_SYNC;
            ST_SYNC: nxt_state = ST_TTAR;
            ST_TTAR: nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         state <= nxt_state;
         cnt   <= nxt_cnt;
      end
   end

   // R3
   id_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_n && state == ST_STRT && nib != strap_id) |=> state == ST_IDLE);

   // R5
   size_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_n && state == ST_SIZE && nib != SIZE_ONE) |=> state == ST_IDLE);

endmodule

// File: rtl/nbus_wr_drv.sv
module nbus_wr_drv
   import nbus_wr_pkg::*;
#(
   parameter int                NIB_W   = 4,
   parameter logic [NIB_W-1:0]  SYNC_OK = 4'b0000
) (
   input  nbus_state_e      state,
   output logic             bus_oe,
   output logic [NIB_W-1:0] bus_out,
   output logic             wr_stb
);

   always_comb begin
      bus_oe  = (state == ST_SYNC) || (state == ST_TTAR);
      bus_out = (state == ST_SYNC) ? SYNC_OK : '1;
      wr_stb  = (state == ST_SYNC);
   end

endmodule

// File: rtl/nbus_wr_target.sv
module nbus_wr_target
   import nbus_wr_pkg::*;
#(
   parameter int                NIB_W      = 4,
   parameter int                ADDR_NIBS  = 7,
   parameter int                DATA_NIBS  = 2,
   parameter logic [NIB_W-1:0]  START_CODE = 4'b1110,
   parameter logic [NIB_W-1:0]  SIZE_ONE   = 4'b0000,
   parameter logic [NIB_W-1:0]  SYNC_OK    = 4'b0000,
   localparam int ADDR_W = NIB_W * ADDR_NIBS,
   localparam int DATA_W = NIB_W * DATA_NIBS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [NIB_W-1:0]  strap_id,
   input  logic [NIB_W-1:0]  bus_in,
   output logic [NIB_W-1:0]  bus_out,
   output logic              bus_oe,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   initial begin
      assert (SYNC_OK != '1);
   end

   nbus_state_e state;
   logic        armed, addr_shift, data_shift;

   nbus_start_track #(.NIB_W(NIB_W), .START_CODE(START_CODE)) u_start (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib(bus_in), .armed(armed)
   );

   nbus_wr_seq #(
      .NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS), .DATA_NIBS(DATA_NIBS), .SIZE_ONE(SIZE_ONE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib(bus_in), .strap_id(strap_id),
      .armed(armed), .state(state), .addr_shift(addr_shift), .data_shift(data_shift)
   );

   nbus_nib_collect #(.NIB_W(NIB_W), .NIBS(ADDR_NIBS), .MSB_FIRST(1'b1)) u_addr (
      .clk(clk), .rst_n(rst_n), .shift(addr_shift), .nib(bus_in), .value(wr_addr)
   );

   nbus_nib_collect #(.NIB_W(NIB_W), .NIBS(DATA_NIBS), .MSB_FIRST(1'b0)) u_data (
      .clk(clk), .rst_n(rst_n), .shift(data_shift), .nib(bus_in), .value(wr_data)
   );

   nbus_wr_drv #(.NIB_W(NIB_W), .SYNC_OK(SYNC_OK)) u_drv (
      .state(state), .bus_oe(bus_oe), .bus_out(bus_out), .wr_stb(wr_stb)
   );

   // R7
   stb_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (bus_oe && bus_out == SYNC_OK));

   // R8
   tar_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && frame_n) |=> (bus_oe && bus_out == '1));

   // R8
   float_after_tar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !wr_stb) |=> !bus_oe);

   // R9
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R9
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));

   // R10
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> (!bus_oe && !wr_stb));

   // R11
   reset_chk: assert property (@(posedge clk)
      !rst_n |=> (!bus_oe && !wr_stb));

endmodule

// File: tb/nbus_wr_target_test.sv
module nbus_wr_target_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  strap_id = 4'h5;
   logic [3:0]  bus_in = 4'hF;
   logic [3:0]  bus_out;
   logic        bus_oe, wr_stb;
   logic [27:0] wr_addr;
   logic [7:0]  wr_data;

   int n_chk = 0;
   int n_fail = 0;

   nbus_wr_target uut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .strap_id(strap_id),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic fr, input logic [3:0] nib, input logic rst = 1'b1);
      @(negedge clk);
      frame_n = fr;
      bus_in  = nib;
      rst_n   = rst;
      @(posedge clk);
      #1;
   endtask

   function automatic bit accept_f(input logic [3:0] st, input logic [3:0] id,
                                   input logic [3:0] sz, input logic [3:0] strap);
      return (st == 4'b1110) && (id == strap) && (sz == 4'b0000);
   endfunction

   function automatic logic [3:0] nib_at(input int i, input logic [3:0] st,
                                         input logic [3:0] id, input logic [3:0] sz,
                                         input logic [27:0] a, input logic [7:0] d);
      if (i == 1)  return st;
      if (i == 2)  return id;
      if (i >= 3 && i <= 9) return 4'(a >> (4 * (9 - i)));
      if (i == 10) return sz;
      if (i == 11) return d[3:0];
      if (i == 12) return d[7:4];
      return 4'hF;
   endfunction

   task automatic run_cycle(input string tag, input int lead, input logic [3:0] lead_nib,
                            input logic [3:0] st, input logic [3:0] id, input logic [3:0] sz,
                            input logic [27:0] a, input logic [7:0] d,
                            input int abort_at, input int rst_at);
      bit    acc, live, exp_oe, exp_stb;
      string stag;
      acc  = accept_f(st, id, sz, strap_id);
      stag = (acc && rst_at == 0) ? "R9" : tag;
      for (int k = 0; k < lead; k++) begin
         step(1'b0, lead_nib);
         chk(!bus_oe && !wr_stb, "R2", "lead start clock quiet", {bus_oe, wr_stb}, 0);
      end
      for (int i = 1; i <= 17; i++) begin
         if (i == abort_at) return;
         step((i == 1) ? 1'b0 : 1'b1, nib_at(i, st, id, sz, a, d), (i == rst_at) ? 1'b0 : 1'b1);
         live    = acc && (rst_at == 0 || i < rst_at);
         exp_oe  = live && (i == 14 || i == 15);
         exp_stb = live && (i == 14);
         chk(bus_oe == exp_oe, (acc && rst_at == 0) ? "R8" : tag, "bus_oe", bus_oe, exp_oe);
         chk(wr_stb == exp_stb, stag, "wr_stb", wr_stb, exp_stb);
         if (exp_stb) begin
            chk(wr_addr == a, "R4", "wr_addr", wr_addr, a);
            chk(wr_data == d, "R6", "wr_data", wr_data, d);
            chk(bus_out == 4'h0, "R7", "sync nibble", bus_out, 0);
         end
         if (exp_oe && i == 15)
            chk(bus_out == 4'hF, "R8", "turnaround nibble", bus_out, 4'hF);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      bit          prev_abort;
      seed_init = $urandom(32'h00C0FFEE);
      prev_abort = 1'b0;

      // R11: reset state
      repeat (3) step(1'b1, 4'hF, 1'b0);
      chk(!bus_oe && !wr_stb, "R11", "reset outputs", {bus_oe, wr_stb}, 0);
      step(1'b1, 4'hF);
      chk(!bus_oe && !wr_stb, "R11", "idle after reset", {bus_oe, wr_stb}, 0);

      // clean writes
      run_cycle("R4", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'h1234567, 8'hA5, 0, 0);
      run_cycle("R6", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'hFEDCBA9, 8'h3C, 0, 0);
      // R1 bad start code
      run_cycle("R1", 0, 4'h0, 4'hD, 4'h5, 4'h0, 28'h0000001, 8'h11, 0, 0);
      // R3 foreign ID
      run_cycle("R3", 0, 4'h0, 4'hE, 4'h6, 4'h0, 28'h0000002, 8'h22, 0, 0);
      // R5 bad size
      run_cycle("R5", 0, 4'h0, 4'hE, 4'h5, 4'h1, 28'h0000003, 8'h33, 0, 0);
      // R2 valid code first, stray last -> reject
      run_cycle("R2", 2, 4'hE, 4'h3, 4'h5, 4'h0, 28'h0000004, 8'h44, 0, 0);
      // R2 stray first, valid last -> accept
      run_cycle("R2", 2, 4'h3, 4'hE, 4'h5, 4'h0, 28'hABCDEF0, 8'h5A, 0, 0);
      // R10 aborts followed by clean frames
      run_cycle("R10", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'h1111111, 8'h66, 9, 0);
      run_cycle("R10", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'hFFFFFFF, 8'h00, 0, 0);
      run_cycle("R10", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'h2222222, 8'h77, 14, 0);
      run_cycle("R10", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'h0000000, 8'hFF, 0, 0);
      // R11 mid-frame resets
      run_cycle("R11", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'h3333333, 8'h88, 0, 15);
      run_cycle("R11", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'h4444444, 8'h99, 0, 8);
      run_cycle("R11", 0, 4'h0, 4'hE, 4'h5, 4'h0, 28'h5555555, 8'hC3, 0, 0);

      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [3:0]  st, id, sz, ln;
         logic [27:0] a;
         logic [7:0]  d;
         int          ab, gap, lead;
         if (!prev_abort) begin
            gap = $urandom_range(0, 2);
            for (int g = 0; g < gap; g++) begin
               step(1'b1, 4'hF);
               chk(!bus_oe && !wr_stb, "R1", "idle gap quiet", {bus_oe, wr_stb}, 0);
            end
            if ($urandom_range(0, 7) == 0) strap_id = 4'($urandom);
         end
         st   = ($urandom_range(0, 4) != 0) ? 4'hE : 4'($urandom);
         id   = ($urandom_range(0, 3) != 0) ? strap_id : 4'($urandom);
         sz   = ($urandom_range(0, 4) != 0) ? 4'h0 : 4'($urandom);
         a    = 28'($urandom);
         d    = 8'($urandom);
         ln   = 4'($urandom);
         lead = $urandom_range(0, 2);
         ab   = ($urandom_range(0, 9) == 0) ? $urandom_range(2, 14) : 0;
         run_cycle((ab != 0) ? "R10" : "R1", lead, ln, st, id, sz, a, d, ab, 0);
         prev_abort = (ab != 0);
      end
      step(1'b1, 4'hF);
      chk(!bus_oe && !wr_stb, "R8", "final idle", {bus_oe, wr_stb}, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule